// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block keeps a multiplexed-address DRAM alive. After reset it holds the memory interface for a power-up pause, then runs eight warm-up refresh cycles on its own. Only after those cycles does it raise a ready flag that lets the access controller start normal traffic. From then on it counts out a refresh interval, asks the access controller for the bus when a refresh falls due, and drives the row and column strobes and the address lines itself while it holds the bus.

A build-time parameter selects one of two refresh styles. In the first style the column strobe is lowered ahead of the row strobe, so the device refreshes the row held in its internal counter. In the second style the block drives a row address from its own counter with the column strobe held high. Refreshes that fall due while the bus is not granted are kept, up to a parameterised limit. Once the bus is granted, the block runs all of the kept refreshes one after another without releasing the bus.

The defaults are set for a 125 MHz clock. The pause is 25000 cycles (200 µs), and the refresh interval is 1950 cycles, which covers 1024 rows within 16 ms.

Top module: `dram_refresh_init`

## Requirements
- R1: In the cycles after reset, rasN, casN and weN are 1, initDone and refReq are 0, and busOwn is 1. This state holds for PAUSE_CYC cycles.
- R2: When the pause ends, exactly eight refresh cycles run without any handshake. initDone rises in the first cycle after the precharge of the eighth cycle has ended, and it never falls again.
- R3: In counter mode (RAS_ONLY=0), casN goes low SETUP_CYC cycles before rasN goes low. casN stays low for CAS_HOLD_CYC cycles after rasN falls, then goes high while rasN is still low.
- R4: Every refresh has three parts: SETUP_CYC cycles with rasN high, then exactly RAS_CYC cycles with rasN low, then PRECH_CYC cycles with rasN high before anything else happens.
- R5: weN is 1 at all times, so the device never enters its test mode.
- R6: In row mode (RAS_ONLY=1), casN stays 1 and addr carries a row counter. The counter starts at 0 and adds one at the end of each refresh, warm-up cycles included. It wraps from 2^ROW_BITS-1 to 0.
- R7: In counter mode, addr is 0.
- R8: After initDone, one refresh becomes due every INTERVAL_CYC cycles. The first one is due INTERVAL_CYC cycles after initDone rises. refReq is 1 exactly when the block is idle and at least one refresh is due.
- R9: A refresh starts in the cycle after the clock edge that samples refReq=1 and refAck=1. refReq drops in that cycle. busOwn stays 1 until the cycle after the precharge of the last refresh.
- R10: At most MAX_DUE unserved refreshes are kept. Any refresh that falls due beyond that limit is dropped.
- R11: If refreshes are still due when a refresh's precharge ends, the next refresh starts at once without a new handshake.
- R12: Whenever busOwn is 0, rasN and casN are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| refAck | input | 1 | bus grant from the access controller |
| refReq | output | 1 | refresh is due and the block is idle |
| busOwn | output | 1 | the block is driving the strobes and address |
| initDone | output | 1 | power-up pause and warm-up cycles are complete |
| rasN | output | 1 | row strobe, active low |
| casN | output | 1 | column strobe, active low |
| weN | output | 1 | write enable, held high |
| addr | output | ROW_BITS | refresh row address (row mode), otherwise 0 |

## Verification
The strobes, address, refReq and busOwn all change in the cycle right after the clock edge that causes the change. A grant sampled at one edge shows up as a strobe change after that same edge. The ready flag appears on the edge that ends the eighth precharge. A due refresh raises refReq right after the edge on which its interval runs out. The bench keeps a behavioural model that it advances on every rising edge from the same inputs as the design, and it compares every output at the following falling edge. A dedicated scenario withholds the grant for five intervals and then grants the bus just after an interval has expired. It then expects exactly the capped number of row-strobe pulses back to back, followed by release in the next cycle.

// File: rtl/drfi_pkg.sv
package drfi_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic rowStep;
    logic take;
    logic timerRun;
  } seqStrobeT;

endpackage

// File: rtl/drfi_ctrl.sv
module drfi_ctrl
  import drfi_pkg::*;
#(
  parameter bit RAS_ONLY     = 1'b0,
  parameter int PAUSE_CYC    = 25000,
  parameter int SETUP_CYC    = 1,
  parameter int RAS_CYC      = 8,
  parameter int CAS_HOLD_CYC = 2,
  parameter int PRECH_CYC    = 5,
  parameter int WARM_CNT     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refAck,
  input  logic      pendAny,
  output seqStrobeT strobe,
  output logic      refReq,
  output logic      busOwn,
  output logic      initDone
);

  localparam int LONG_A = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
  localparam int LONG_B = (PRECH_CYC > SETUP_CYC) ? PRECH_CYC : SETUP_CYC;
  localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int PH_W = $clog2(LONGEST + 1);
  localparam int WARM_W = $clog2(WARM_CNT + 1);

  seqStateT          state, nextState;
  logic [PH_W-1:0]   phCnt;
  logic [WARM_W-1:0] warmCnt;
  logic              initQ;
  int                limit;
  logic              phLast, endRef, warmLast, startIdle, casLowW;

  always_comb begin
    case (state)
      ST_PAUSE:  limit = PAUSE_CYC;
      ST_SETUP:  limit = SETUP_CYC;
      ST_ACTIVE: limit = RAS_CYC;
      ST_PRECH:  limit = PRECH_CYC;
      default:   limit = 1;
    endcase
  end

  assign phLast    = (phCnt == PH_W'(limit - 1));
  assign endRef    = (state == ST_PRECH) && phLast;
  assign warmLast  = (warmCnt == WARM_W'(WARM_CNT - 1));
  assign startIdle = (state == ST_IDLE) && pendAny && refAck;

  always_comb begin
    nextState = state;
    case (state)
      ST_PAUSE:  if (phLast) nextState = ST_SETUP;
      ST_IDLE:   if (startIdle) nextState = ST_SETUP;
      ST_SETUP:  if (phLast) nextState = ST_ACTIVE;
      ST_ACTIVE: if (phLast) nextState = ST_PRECH;
      ST_PRECH: begin
        if (phLast) begin
          if (!initQ) nextState = warmLast ? ST_IDLE : ST_SETUP;
          else        nextState = pendAny ? ST_SETUP : ST_IDLE;
        end
      end
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PAUSE;
      phCnt   <= '0;
      warmCnt <= '0;
      initQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state || state == ST_IDLE) phCnt <= '0;
      else                                        phCnt <= phCnt + 1'b1;
      if (endRef && !initQ) begin
        warmCnt <= warmCnt + 1'b1;
        if (warmLast) initQ <= 1'b1;
      end
    end
  end

  generate
    if (RAS_ONLY) begin : g_rowMode
      assign casLowW = 1'b0;
    end else begin : g_cbrMode
      assign casLowW = (state == ST_SETUP) ||
                       ((state == ST_ACTIVE) && (phCnt < PH_W'(CAS_HOLD_CYC)));
      // R3: column strobe already low when the row strobe falls
      a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rstN)
        $rose(strobe.rasLow) |-> $past(strobe.casLow));
    end
  endgenerate

  assign strobe.rasLow   = (state == ST_ACTIVE);
  assign strobe.casLow   = casLowW;
  assign strobe.rowStep  = endRef;
  assign strobe.take     = startIdle || (endRef && initQ && pendAny);
  assign strobe.timerRun = initQ;

  assign refReq   = (state == ST_IDLE) && pendAny;
  assign busOwn   = (state != ST_IDLE);
  assign initDone = initQ;

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initQ |=> initQ);
  a_r2_ready_after_prech: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initQ) |-> $past(state) == ST_PRECH);
  a_r8_req_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> initDone);
  a_r9_grant_starts: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refAck) |=> (busOwn && !refReq && state == ST_SETUP));

endmodule

// File: rtl/drfi_dpath.sv
module drfi_dpath
  import drfi_pkg::*;
#(
  parameter bit RAS_ONLY     = 1'b0,
  parameter int ROW_BITS     = 10,
  parameter int INTERVAL_CYC = 1950,
  parameter int MAX_DUE      = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobeT           strobe,
  output logic                pendAny,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic [ROW_BITS-1:0] addr
);

  localparam int TMR_W = $clog2(INTERVAL_CYC);
  localparam int DUE_W = $clog2(MAX_DUE + 1);

  logic [TMR_W-1:0]    tmr;
  logic [DUE_W-1:0]    due;
  logic [ROW_BITS-1:0] rowCnt;
  logic                tick;

  assign tick = strobe.timerRun && (tmr == TMR_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tmr <= '0;
    else if (!strobe.timerRun) tmr <= '0;
    else if (tick)             tmr <= '0;
    else                       tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) due <= '0;
    else begin
      case ({tick, strobe.take})
        2'b10:   if (due != DUE_W'(MAX_DUE)) due <= due + 1'b1;
        2'b01:   due <= due - 1'b1;
        default: due <= due;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rowCnt <= '0;
    else if (strobe.rowStep) rowCnt <= rowCnt + 1'b1;
  end

  assign pendAny = (due != '0);
  assign rasN    = ~strobe.rasLow;
  assign casN    = ~strobe.casLow;
  assign weN     = 1'b1;
  assign addr    = RAS_ONLY ? rowCnt : '0;

  a_r10_due_capped: assert property (@(posedge clk) disable iff (!rstN)
    due <= DUE_W'(MAX_DUE));
  a_r11_take_has_due: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> pendAny);
  a_r8_due_grows: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.take && due < DUE_W'(MAX_DUE)) |=> due == $past(due) + 1'b1);
  a_r6_row_steps: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rowStep |=> rowCnt == $past(rowCnt) + 1'b1);

endmodule

// File: rtl/dram_refresh_init.sv
module dram_refresh_init #(
  parameter bit RAS_ONLY     = 1'b0,
  parameter int ROW_BITS     = 10,
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950,
  parameter int MAX_DUE      = 4,
  parameter int SETUP_CYC    = 1,
  parameter int RAS_CYC      = 8,
  parameter int CAS_HOLD_CYC = 2,
  parameter int PRECH_CYC    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refAck,
  output logic                refReq,
  output logic                busOwn,
  output logic                initDone,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic [ROW_BITS-1:0] addr
);

  drfi_pkg::seqStrobeT strobe;
  logic pendAny;

  drfi_ctrl #(
    .RAS_ONLY(RAS_ONLY), .PAUSE_CYC(PAUSE_CYC), .SETUP_CYC(SETUP_CYC),
    .RAS_CYC(RAS_CYC), .CAS_HOLD_CYC(CAS_HOLD_CYC), .PRECH_CYC(PRECH_CYC),
    .WARM_CNT(8)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .refAck(refAck), .pendAny(pendAny),
    .strobe(strobe), .refReq(refReq), .busOwn(busOwn), .initDone(initDone)
  );

  drfi_dpath #(
    .RAS_ONLY(RAS_ONLY), .ROW_BITS(ROW_BITS),
    .INTERVAL_CYC(INTERVAL_CYC), .MAX_DUE(MAX_DUE)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendAny(pendAny),
    .rasN(rasN), .casN(casN), .weN(weN), .addr(addr)
  );

  a_r12_released_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busOwn |-> (rasN && casN));

endmodule

// File: tb/dram_refresh_init_test.sv
module dram_refresh_init_test;

  localparam int RB = 4;
  localparam int PAUSE = 30;
  localparam int INTV = 50;
  localparam int MAXD = 3;
  localparam int SU = 1;
  localparam int RASC = 4;
  localparam int HOLD = 2;
  localparam int PRE = 3;
  localparam int LEN = SU + RASC + PRE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] ack = 2'b00;
  logic [1:0] refReq, busOwn, initDone, rasN, casN, weN;
  logic [RB-1:0] addr [2];

  int total = 0;
  int bad = 0;
  bit checking = 0;

  dram_refresh_init #(.RAS_ONLY(1'b0), .ROW_BITS(RB), .PAUSE_CYC(PAUSE),
    .INTERVAL_CYC(INTV), .MAX_DUE(MAXD), .SETUP_CYC(SU), .RAS_CYC(RASC),
    .CAS_HOLD_CYC(HOLD), .PRECH_CYC(PRE)) uut (
    .clk(clk), .rstN(rstN), .refAck(ack[0]), .refReq(refReq[0]),
    .busOwn(busOwn[0]), .initDone(initDone[0]), .rasN(rasN[0]),
    .casN(casN[0]), .weN(weN[0]), .addr(addr[0]));

  dram_refresh_init #(.RAS_ONLY(1'b1), .ROW_BITS(RB), .PAUSE_CYC(PAUSE),
    .INTERVAL_CYC(INTV), .MAX_DUE(MAXD), .SETUP_CYC(SU), .RAS_CYC(RASC),
    .CAS_HOLD_CYC(HOLD), .PRECH_CYC(PRE)) uut_row (
    .clk(clk), .rstN(rstN), .refAck(ack[1]), .refReq(refReq[1]),
    .busOwn(busOwn[1]), .initDone(initDone[1]), .rasN(rasN[1]),
    .casN(casN[1]), .weN(weN[1]), .addr(addr[1]));

  // reference model: 0 pause, 1 idle, 2 refreshing
  int mPhase[2], mCnt[2], mPos[2], mWarm[2], mDue[2], mTmr[2], mRow[2];
  bit mInit[2], mTick[2];

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rstN) begin
        mPhase[m] = 0; mCnt[m] = 0; mPos[m] = 0; mWarm[m] = 0;
        mDue[m] = 0; mTmr[m] = 0; mRow[m] = 0; mInit[m] = 0; mTick[m] = 0;
      end else begin
        int dueOld;
        bit tk;
        bit tkn;
        dueOld = mDue[m]; tk = 0; tkn = 0;
        if (mInit[m]) begin
          mTmr[m]++;
          if (mTmr[m] == INTV) begin tk = 1; mTmr[m] = 0; end
        end
        case (mPhase[m])
          0: begin
            mCnt[m]++;
            if (mCnt[m] == PAUSE) begin mPhase[m] = 2; mPos[m] = 0; end
          end
          1: if (dueOld > 0 && ack[m]) begin
            mPhase[m] = 2; mPos[m] = 0; tkn = 1;
          end
          default: begin
            mPos[m]++;
            if (mPos[m] == LEN) begin
              mPos[m] = 0;
              if (m == 1) mRow[m] = (mRow[m] + 1) % (1 << RB);
              if (!mInit[m]) begin
                mWarm[m]++;
                if (mWarm[m] == 8) begin mInit[m] = 1; mPhase[m] = 1; end
              end else if (dueOld > 0) tkn = 1;
              else mPhase[m] = 1;
            end
          end
        endcase
        mDue[m] = dueOld + int'(tk) - int'(tkn);
        if (mDue[m] > MAXD) mDue[m] = MAXD;
        mTick[m] = tk;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && checking) begin
      for (int m = 0; m < 2; m++) begin
        bit busy;
        bit eRas;
        bit eCas;
        busy = (mPhase[m] == 2);
        eRas = !(busy && mPos[m] >= SU && mPos[m] < SU + RASC);
        eCas = !(m == 0 && busy && mPos[m] < SU + HOLD);
        chk(rasN[m] == eRas, "R4 rasN", rasN[m], eRas);
        if (m == 0) chk(casN[m] == eCas, "R3 casN", casN[m], eCas);
        else        chk(casN[m] == eCas, "R6 casN", casN[m], eCas);
        if (m == 0) chk(addr[m] == 0, "R7 addr", addr[m], 0);
        else        chk(int'(addr[m]) == mRow[m], "R6 addr", addr[m], mRow[m]);
        chk(weN[m] == 1'b1, "R5 weN", weN[m], 1);
        chk(refReq[m] == (mPhase[m] == 1 && mDue[m] > 0), "R8 refReq",
            refReq[m], (mPhase[m] == 1 && mDue[m] > 0));
        chk(busOwn[m] == (mPhase[m] != 1), "R9 busOwn", busOwn[m], mPhase[m] != 1);
        chk(initDone[m] == mInit[m], "R2 initDone", initDone[m], mInit[m]);
        if (!busOwn[m]) chk(rasN[m] && casN[m], "R12 idle strobes",
                            {rasN[m], casN[m]}, 3);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    int ticks;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state before the first edge
    for (int m = 0; m < 2; m++) begin
      chk(rasN[m] && casN[m] && weN[m], "R1 strobes high",
          {rasN[m], casN[m], weN[m]}, 7);
      chk(!initDone[m] && !refReq[m] && busOwn[m], "R1 flags",
          {initDone[m], refReq[m], busOwn[m]}, 1);
    end
    checking = 1;
    ack = 2'b11;
    repeat (450) @(negedge clk);
    // R10/R11: withhold the grant for five intervals
    ack = 2'b00;
    ticks = 0;
    while (ticks < 5) begin
      @(negedge clk);
      if (mTick[0]) ticks++;
    end
    ack = 2'b11;
    begin
      int falls[2];
      bit held[2];
      logic [1:0] prevRas;
      falls[0] = 0; falls[1] = 0; held[0] = 1; held[1] = 1;
      prevRas = rasN;
      for (int c = 0; c < 3 * LEN; c++) begin
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
          if (prevRas[m] && !rasN[m]) falls[m]++;
          if (!busOwn[m]) held[m] = 0;
        end
        prevRas = rasN;
      end
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        chk(falls[m] == MAXD, "R10 capped due count", falls[m], MAXD);
        chk(held[m], "R11 back to back on one grant", held[m], 1);
        chk(!busOwn[m], "R11 release after last", busOwn[m], 0);
      end
    end
    // mixed grant pattern
    lfsr = 8'hA5;
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ack = lfsr[1:0];
    end
    @(negedge clk);
    checking = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule